// File: doc/BRIEF.md
# Pixel-Pair LSB Matching Secret Extractor

This block pulls hidden secret bytes out of a stream of grayscale stego pixels. The embedder hid those bytes two bits per pixel pair. Pixels arrive as non-overlapping pairs, one pair per clock, with a valid qualifier. Each pair yields two secret bits. The first bit is the least significant bit of the first pixel. The second bit is the parity of half the first pixel (rounded down) plus the second pixel.

The recovered bits fill an 8-entry bit buffer from the top index downwards. Four consecutive pairs therefore make one secret byte, most significant bit first. Each finished byte is presented for a single cycle together with its sequential byte address. After a configured number of bytes, extraction stops, a done flag rises and stays high, and further pixels are ignored.

Top module: `stego_pair_extractor`

## Requirements
- R1: After reset, byte_valid is 0, done is 0, and the first byte produced carries address 0.
- R2: The first bit taken from each pair equals bit 0 of the first pixel (pix_a).
- R3: The second bit taken from each pair equals bit 0 of floor(pix_a/2) + pix_b, computed without losing the carry. Pixel values 0 and 255 are included.
- R4: Pairs do not overlap. Four accepted pairs form one byte: the first pair supplies byte bits 7 and 6, the second bits 5 and 4, the third bits 3 and 2, and the fourth bits 1 and 0. Within each pair, the R2 bit takes the higher position.
- R5: byte_valid is high for exactly one cycle, in the cycle that follows the clock edge accepting the fourth pair of a byte. byte_data and byte_addr are valid in that same cycle.
- R6: Byte addresses start at 0 and rise by one for each byte produced.
- R7: A cycle with in_valid low consumes no pair and loses no partly assembled bits.
- R8: done rises together with the byte_valid of byte NUM_BYTES-1 and stays high until reset. After that, accepted input produces no further byte_valid.
- R9: The pairs (162,151), (162,150), (161,150), (163,150) decode to bit pairs 00, 01, 10, 11. Fed in that order, they produce byte 0x1B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel pair is present this cycle |
| pix_a | input | PIX_W | First pixel of the pair |
| pix_b | input | PIX_W | Second pixel of the pair |
| byte_valid | output | 1 | One-cycle strobe for a finished secret byte |
| byte_data | output | BYTE_W | Recovered secret byte |
| byte_addr | output | ADDR_W | Sequence address of the recovered byte |
| done | output | 1 | Configured byte count reached; sticky until reset |

## Verification
The hardest case to reach is a byte whose four pairs are spread across stalls, with in_valid dropping between the second and third pair. In that case the partial buffer and the bit index must survive idle cycles. The bench drives long runs of random pairs through a randomly gated in_valid, so every stall position within a byte occurs many times. A behavioural reference model is compared with the outputs on every cycle. The stream is then continued past the last byte, to show that done is sticky and that input after completion is ignored.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef struct packed {
    logic hi;   // bit from first pixel LSB
    logic lo;   // parity bit of half-first plus second
  } bit_pair_t;
endpackage

// File: rtl/stx_pair_decode.sv
module stx_pair_decode #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0]  first_pix,
  input  logic [PIX_W-1:0]  second_pix,
  output stx_pkg::bit_pair_t bits
);
  function automatic logic low_bit_of(input logic [PIX_W-1:0] p);
    return p[0];
  endfunction

  function automatic logic half_sum_parity(input logic [PIX_W-1:0] p, input logic [PIX_W-1:0] q);
    logic [PIX_W:0] s;
    s = {1'b0, (p >> 1)} + {1'b0, q};
    return s[0];
  endfunction

  always_comb begin
    bits.hi = low_bit_of(first_pix);
    bits.lo = half_sum_parity(first_pix, second_pix);
  end
endmodule

// File: rtl/stx_bit_packer.sv
module stx_bit_packer #(
  parameter int BYTE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  stx_pkg::bit_pair_t bits,
  output logic               byte_done,
  output logic [BYTE_W-1:0]  byte_val
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BYTE_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] buf_q;
  logic [BYTE_W-1:0] buf_nxt;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_slot
    always_comb begin
      if (take && idx_q == IDX_W'(i))
        buf_nxt[i] = bits.hi;
      else if (take && idx_q == IDX_W'(i + 1))
        buf_nxt[i] = bits.lo;
      else
        buf_nxt[i] = buf_q[i];
    end
  end

  assign byte_done = take && (idx_q == IDX_W'(1));
  assign byte_val  = buf_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= TOP_IDX;
      buf_q <= '0;
    end else begin
      buf_q <= buf_nxt;
      if (take)
        idx_q <= byte_done ? TOP_IDX : idx_q - IDX_W'(2);
    end
  end
endmodule

// File: rtl/stx_byte_tracker.sv
module stx_byte_tracker #(
  parameter int NUM_BYTES = 1024,
  parameter int ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              done_q
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      done_q   <= 1'b0;
    end else if (byte_done) begin
      cur_addr <= cur_addr + ADDR_W'(1);
      if (cur_addr == LAST_ADDR)
        done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/stego_pair_extractor.sv
module stego_pair_extractor #(
  parameter int PIX_W     = 8,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 1024,
  parameter int ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  pix_a,
  input  logic [PIX_W-1:0]  pix_b,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              done
);
  stx_pkg::bit_pair_t pair_bits;
  logic               pair_take;
  logic               byte_fill;
  logic [BYTE_W-1:0]  byte_next;
  logic [ADDR_W-1:0]  seq_addr;

  assign pair_take = in_valid && !done;

  stx_pair_decode #(.PIX_W(PIX_W)) u_dec (
    .first_pix (pix_a),
    .second_pix(pix_b),
    .bits      (pair_bits)
  );

  stx_bit_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (pair_take),
    .bits     (pair_bits),
    .byte_done(byte_fill),
    .byte_val (byte_next)
  );

  stx_byte_tracker #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_done(byte_fill),
    .cur_addr (seq_addr),
    .done_q   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_addr  <= '0;
    end else begin
      byte_valid <= byte_fill;
      if (byte_fill) begin
        byte_data <= byte_next;
        byte_addr <= seq_addr;
      end
    end
  end
endmodule

// File: rtl/stx_extract_checks.sv
module stx_extract_checks #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              pair_take,
  input logic              byte_valid,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              done
);
  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) next_addr <= '0;
    else if (byte_valid) next_addr <= next_addr + ADDR_W'(1);
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R5
  strobe_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(pair_take));

  // R6
  addr_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> byte_addr == next_addr);

  // R7
  stall_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !byte_valid);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !byte_valid);
endmodule

bind stego_pair_extractor stx_extract_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .pair_take (pair_take),
  .byte_valid(byte_valid),
  .byte_addr (byte_addr),
  .done      (done)
);

// File: tb/stego_pair_extractor_bench.sv
module stego_pair_extractor_bench;
  localparam int NB = 6;
  localparam int AW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    pix_a = '0;
  logic [7:0]    pix_b = '0;
  logic          byte_valid;
  logic [7:0]    byte_data;
  logic [AW-1:0] byte_addr;
  logic          done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  stego_pair_extractor #(.PIX_W(8), .BYTE_W(8), .NUM_BYTES(NB)) u_stego_pair_extractor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_a(pix_a), .pix_b(pix_b),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_addr(byte_addr), .done(done)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit    bits_q[$];
  int    m_bytes;
  bit    e_valid, e_done;
  int    e_data, e_addr;

  function automatic bit ref_second(int a, int b);
    return ((a / 2 + b) % 2) == 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      bits_q.delete(); m_bytes = 0; e_valid = 0; e_done = 0; e_data = 0; e_addr = 0;
    end else begin
      e_valid = 0;
      if (in_valid && !e_done) begin
        bits_q.push_back(bit'(pix_a % 2));
        bits_q.push_back(ref_second(int'(pix_a), int'(pix_b)));
        if (bits_q.size() == 8) begin
          e_data = 0;
          for (int k = 0; k < 8; k++) e_data = e_data * 2 + int'(bits_q[k]);
          bits_q.delete();
          e_valid = 1; e_addr = m_bytes; m_bytes++;
          if (m_bytes == NB) e_done = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      // R5 R7 strobe timing, R8 done
      check(byte_valid == e_valid, "R5", "byte_valid", int'(byte_valid), int'(e_valid));
      check(done == e_done, "R8", "done", int'(done), int'(e_done));
      if (e_valid && byte_valid) begin
        // R4 packing order, R2 R3 bits
        check(byte_data == 8'(e_data), "R4", "byte_data", int'(byte_data), e_data);
        // R6 address
        check(int'(byte_addr) == e_addr, "R6", "byte_addr", int'(byte_addr), e_addr);
      end
    end
  end

  task automatic send(input logic v, input int a, input int b);
    in_valid = v; pix_a = 8'(a); pix_b = 8'(b);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(byte_valid == 1'b0, "R1", "byte_valid", int'(byte_valid), 0);
    check(done == 1'b0, "R1", "done", int'(done), 0);

    // R9 reference vectors, byte 0 at address 0
    send(1, 162, 151); send(1, 162, 150); send(1, 161, 150); send(1, 163, 150);
    check(byte_valid == 1'b1, "R9", "strobe", int'(byte_valid), 1);
    check(byte_data == 8'h1B, "R9", "byte", int'(byte_data), 27);
    check(byte_addr == '0, "R1", "first addr", int'(byte_addr), 0);

    // R3 saturated pixels: 255,255 -> bits 1,0
    send(1, 255, 255); send(1, 255, 255); send(1, 255, 255); send(1, 255, 255);
    check(byte_data == 8'hAA, "R3", "byte", int'(byte_data), 170);

    // R2 with stalls mid-byte (R7): (3,0)->11, (2,1)->00
    send(1, 3, 0); send(1, 2, 1); send(0, 255, 255); send(0, 1, 0);
    check(byte_valid == 1'b0, "R7", "strobe during stall", int'(byte_valid), 0);
    send(1, 3, 0); send(0, 0, 0); send(1, 2, 1);
    check(byte_data == 8'hCC, "R2", "byte", int'(byte_data), 204);
    check(byte_addr == AW'(2), "R6", "addr", int'(byte_addr), 2);

    // random stream with random stalls until done
    for (int n = 0; n < 200 && !done; n++)
      send(($urandom % 3) != 0, int'($urandom % 256), int'($urandom % 256));
    check(done == 1'b1, "R8", "done reached", int'(done), 1);

    // R8 input after done ignored
    for (int n = 0; n < 12; n++) begin
      send(1, int'($urandom % 256), int'($urandom % 256));
      check(byte_valid == 1'b0, "R8", "strobe after done", int'(byte_valid), 0);
    end
    check(done == 1'b1, "R8", "done sticky", int'(done), 1);

    // reset again restarts at address 0
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    send(1, 162, 151); send(1, 162, 150); send(1, 161, 150); send(1, 163, 150);
    check(byte_addr == '0, "R1", "addr after reset", int'(byte_addr), 0);
    check(byte_data == 8'h1B, "R9", "byte after reset", int'(byte_data), 27);
    send(0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule